// File: doc/BRIEF.md
# MAC Statistics Counter Bank

This block keeps the event counters of a 10G Ethernet MAC. Each counter is a free-running accumulator of up to 40 bits. Every clock it adds a small unsigned amount taken from its own increment field, so a frame counter adds one and an octet counter adds the bytes seen that cycle. Logic outside the block decides which counter an event belongs to.

Software reads the counters through a 16-bit register port. A snapshot command copies every live counter into a readable shadow in one cycle, so a multi-word read gives values that all belong to the same instant. A clear command zeroes the live counters. When a counter wraps, its bit is set in a 64-bit rollover map, which is read as four clear-on-read words. Four mask words select which rollover bits raise the overflow interrupt. With all masks at zero the interrupt stays low and software polls the map.

Top module: `mac_stat_bank`

## Requirements
- R1: After reset all live counters, shadows, rollover bits and mask bits are zero, `rdata_o` is zero and `irq_o` is low.
- R2: Each cycle, counter i adds the unsigned value of field i of `inc_i` (bits i*INC_W+INC_W-1 down to i*INC_W) and keeps the low CTR_W bits of the sum.
- R3: A write to address 0 with data bit 0 set copies every live counter into its shadow, taking the value from before that cycle's increment. The increment of that cycle still reaches the live counter.
- R4: A read is registered: `rdata_o` takes the new value on the clock edge that samples `rd_en_i` and then holds until the next read. Address CTR_BASE+4*i+s returns shadow i: bits 15:0 for s=0, bits 31:16 for s=1, bits 39:32 in the low byte with zeros above for s=2, and zero for s=3. Shadow bits above CTR_W read as zero.
- R5: A write to address 0 with data bit 1 set zeroes every live counter and drops that cycle's increments. Shadows, rollover bits and masks are unchanged. When bits 0 and 1 are set in the same write, the shadows receive the values from before the clear.
- R6: When the sum in R2 exceeds 2^CTR_W-1, the counter's rollover bit is set. An increment dropped by a clear does not set it.
- R7: Rollover word k is read at address 4+k, and bit j of it belongs to counter 16k+j. The read returns the word and then clears it. A bit whose counter wraps in the same cycle as the read stays set.
- R8: Mask word k is read and written at address 8+k with the same bit layout as R7. A read in the same cycle as a write returns the old value. `irq_o` is high in every cycle in which some rollover bit and its mask bit are both set.
- R9: These read as zero: address 0, addresses 1 to 3 and 12 to CTR_BASE-1, counter addresses whose index is NUM_CTR or above, and rollover bits of counters that do not exist. A write to any address other than 0 and 8 to 11 changes nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| inc_i | input | NUM_CTR*INC_W | Per-counter increment amounts |
| wr_en_i | input | 1 | Register write strobe |
| rd_en_i | input | 1 | Register read strobe |
| addr_i | input | ADDR_W | Register word address |
| wdata_i | input | 16 | Write data |
| rdata_o | output | 16 | Registered read data |
| irq_o | output | 1 | Masked overflow interrupt |

## Verification
The bench builds two instances that share one register bus. The first has eight 40-bit counters, which exercises the full 16+16+8 read slicing and out-of-range counter reads. The second has twenty 10-bit counters with 4-bit increments. Those counters wrap after a few dozen busy cycles, so the bench can reach rollover setting, rollover reads that coincide with wraps, rollover words that span the boundary between two words, and the masked interrupt within a short run.

// File: rtl/mac_stat_bank.sv
module mac_stat_bank #(
  parameter int NUM_CTR  = 64,
  parameter int CTR_W    = 40,
  parameter int INC_W    = 4,
  parameter int ADDR_W   = 10,
  parameter int CTR_BASE = 256
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic [NUM_CTR*INC_W-1:0] inc_i,
  input  logic                     wr_en_i,
  input  logic                     rd_en_i,
  input  logic [ADDR_W-1:0]        addr_i,
  input  logic [15:0]              wdata_i,
  output logic [15:0]              rdata_o,
  output logic                     irq_o
);
  timeunit 1ns;
  timeprecision 1ps;

  localparam int FLAGS = 64;
  localparam int IDX_W = $clog2(NUM_CTR);
  localparam logic [ADDR_W-1:0] CTRL_A = '0;
  localparam logic [ADDR_W-1:0] ROLL_A = ADDR_W'(4);
  localparam logic [ADDR_W-1:0] MASK_A = ADDR_W'(8);
  localparam logic [ADDR_W-1:0] BASE_L = ADDR_W'(CTR_BASE);
  localparam logic [ADDR_W-3:0] NUM_L  = (ADDR_W-2)'(NUM_CTR);

  logic [CTR_W-1:0] live_q [NUM_CTR];
  logic [CTR_W-1:0] shad_q [NUM_CTR];
  logic [CTR_W:0]   sum    [NUM_CTR];
  logic [FLAGS-1:0] roll_q, mask_q, wrap, roll_rd;
  logic [ADDR_W-1:0] off;
  logic [47:0] cval;
  logic [15:0] rd_mux;
  logic snap, clr, ctr_hit, roll_hit, mask_hit;

  assign snap     = wr_en_i && addr_i == CTRL_A && wdata_i[0];
  assign clr      = wr_en_i && addr_i == CTRL_A && wdata_i[1];
  assign roll_hit = addr_i[ADDR_W-1:2] == ROLL_A[ADDR_W-1:2];
  assign mask_hit = addr_i[ADDR_W-1:2] == MASK_A[ADDR_W-1:2];
  assign off      = addr_i - BASE_L;
  assign ctr_hit  = addr_i >= BASE_L && off[ADDR_W-1:2] < NUM_L;
  assign cval     = 48'(shad_q[off[IDX_W+1:2]]);
  assign roll_rd  = (rd_en_i && roll_hit) ? (FLAGS'(16'hffff) << {addr_i[1:0], 4'b0000}) : '0;
  assign irq_o    = |(roll_q & mask_q);

  generate
    for (genvar i = 0; i < NUM_CTR; i++) begin : g_sum
      assign sum[i] = {1'b0, live_q[i]} +
                      {{(CTR_W+1-INC_W){1'b0}}, inc_i[i*INC_W +: INC_W]};
    end
  endgenerate

  always_comb begin
    wrap = '0;
    for (int i = 0; i < NUM_CTR; i++) wrap[i] = sum[i][CTR_W] & ~clr;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < NUM_CTR; i++) begin
        live_q[i] <= '0;
        shad_q[i] <= '0;
      end
    end else begin
      for (int i = 0; i < NUM_CTR; i++) begin
        if (snap) shad_q[i] <= live_q[i];
        live_q[i] <= clr ? '0 : sum[i][CTR_W-1:0];
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      roll_q <= '0;
      mask_q <= '0;
    end else begin
      roll_q <= (roll_q & ~roll_rd) | wrap;
      if (wr_en_i && mask_hit) mask_q[{addr_i[1:0], 4'b0000} +: 16] <= wdata_i;
    end
  end

  always_comb begin
    rd_mux = '0;
    if (ctr_hit) begin
      case (addr_i[1:0])
        2'd0:    rd_mux = cval[15:0];
        2'd1:    rd_mux = cval[31:16];
        2'd2:    rd_mux = {8'h00, cval[39:32]};
        default: rd_mux = '0;
      endcase
    end else if (roll_hit) begin
      rd_mux = roll_q[{addr_i[1:0], 4'b0000} +: 16];
    end else if (mask_hit) begin
      rd_mux = mask_q[{addr_i[1:0], 4'b0000} +: 16];
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n)       rdata_o <= '0;
    else if (rd_en_i) rdata_o <= rd_mux;
  end

  generate
    for (genvar i = 0; i < NUM_CTR; i++) begin : g_chk
      assert_snap_copy_R3: assert property (@(posedge clk) disable iff (!rst_n)
        snap |=> shad_q[i] == $past(live_q[i]));
      assert_clear_zero_R5: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> live_q[i] == '0);
      assert_wrap_flag_R6: assert property (@(posedge clk) disable iff (!rst_n)
        wrap[i] |=> roll_q[i]);
      assert_roll_clear_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (roll_rd[i] && !wrap[i]) |=> !roll_q[i]);
    end
  endgenerate

  assert_top_byte_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en_i && ctr_hit && addr_i[1:0] == 2'd2) |=> rdata_o[15:8] == 8'h00);
  assert_ctrl_read_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en_i && addr_i == CTRL_A) |=> rdata_o == 16'h0000);

endmodule

// File: tb/mac_stat_bank_tb_top.sv
module stat_model #(
  parameter int NUM = 8, parameter int W = 40, parameter int IW = 4, parameter int BASE = 256
) (
  input logic clk, input logic rst_n,
  input logic [NUM*IW-1:0] inc,
  input logic wr, input logic rd, input logic [9:0] addr, input logic [15:0] wdata,
  input logic [15:0] rdata, input logic irq, input int phase
);
  timeunit 1ns;
  timeprecision 1ps;
  longint live [NUM];
  longint shad [NUM];
  logic [63:0] roll, mask, nroll;
  logic [15:0] exp_rd;
  int tag;
  int checks = 0;
  int errors = 0;

  function automatic logic [15:0] value_at(input logic [9:0] a);
    int idx;
    longint v;
    if (a >= 10'(BASE)) begin
      idx = (int'(a) - BASE) / 4;
      if (idx < NUM) begin
        v = shad[idx];
        case (a[1:0])
          2'd0: return 16'(v & 64'hffff);
          2'd1: return 16'((v >> 16) & 64'hffff);
          2'd2: return 16'((v >> 32) & 64'hff);
          default: return 16'h0;
        endcase
      end
      return 16'h0;
    end
    if (a >= 4 && a < 8) return roll[16*(a-4) +: 16];
    if (a >= 8 && a < 12) return mask[16*(a-8) +: 16];
    return 16'h0;
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < NUM; i++) begin live[i] = 0; shad[i] = 0; end
      roll = '0; mask = '0; exp_rd = '0; tag = 1;
    end else begin
      logic snap, clr;
      longint s;
      snap = wr && addr == 0 && wdata[0];
      clr  = wr && addr == 0 && wdata[1];
      if (rd) begin exp_rd = value_at(addr); tag = phase; end
      nroll = roll;
      if (rd && addr >= 4 && addr < 8) nroll[16*(addr-4) +: 16] = 16'h0;
      for (int i = 0; i < NUM; i++) begin
        s = live[i] + longint'(inc[i*IW +: IW]);
        if (snap) shad[i] = live[i];
        if (clr) live[i] = 0;
        else begin
          if (s >= (longint'(1) << W)) begin
            nroll[i] = 1'b1;
            s = s - (longint'(1) << W);
          end
          live[i] = s;
        end
      end
      roll = nroll;
      if (wr && addr >= 8 && addr < 12) mask[16*(addr-8) +: 16] = wdata;
    end
  end

  always @(negedge clk) begin
    if (rst_n) begin
      checks += 2;
      if (rdata !== exp_rd) begin
        errors++;
        $display("FAIL R%0d rdata (W=%0d) got %h expected %h", tag, W, rdata, exp_rd);
      end
      if (irq !== |(roll & mask)) begin
        errors++;
        $display("FAIL R8 irq (W=%0d) got %b expected %b", W, irq, |(roll & mask));
      end
    end
  end
endmodule

module mac_stat_bank_tb_top;
  timeunit 1ns;
  timeprecision 1ps;

  localparam int NA = 8, WA = 40, NB = 20, WB = 10, IW = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic wr = 1'b0, rd = 1'b0;
  logic [9:0] addr = '0;
  logic [15:0] wdata = '0;
  logic [NA*IW-1:0] inc_a = '0;
  logic [NB*IW-1:0] inc_b = '0;
  logic [15:0] rdata_a, rdata_b;
  logic irq_a, irq_b;
  int phase = 1;
  int inc_mode = 0;
  int checks = 0, errors = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  mac_stat_bank #(.NUM_CTR(NA), .CTR_W(WA), .INC_W(IW)) dut_i (
    .clk(clk), .rst_n(rst_n), .inc_i(inc_a), .wr_en_i(wr), .rd_en_i(rd),
    .addr_i(addr), .wdata_i(wdata), .rdata_o(rdata_a), .irq_o(irq_a));
  mac_stat_bank #(.NUM_CTR(NB), .CTR_W(WB), .INC_W(IW)) dut_b (
    .clk(clk), .rst_n(rst_n), .inc_i(inc_b), .wr_en_i(wr), .rd_en_i(rd),
    .addr_i(addr), .wdata_i(wdata), .rdata_o(rdata_b), .irq_o(irq_b));

  stat_model #(.NUM(NA), .W(WA), .IW(IW)) ref_a (
    .clk(clk), .rst_n(rst_n), .inc(inc_a), .wr(wr), .rd(rd), .addr(addr),
    .wdata(wdata), .rdata(rdata_a), .irq(irq_a), .phase(phase));
  stat_model #(.NUM(NB), .W(WB), .IW(IW)) ref_b (
    .clk(clk), .rst_n(rst_n), .inc(inc_b), .wr(wr), .rd(rd), .addr(addr),
    .wdata(wdata), .rdata(rdata_b), .irq(irq_b), .phase(phase));

  always @(posedge clk) begin
    #1;
    for (int i = 0; i < NA; i++)
      inc_a[i*IW +: IW] <= (inc_mode == 0) ? 4'h0 : (inc_mode == 2) ? 4'hf : 4'($urandom);
    for (int i = 0; i < NB; i++)
      inc_b[i*IW +: IW] <= (inc_mode == 0) ? 4'h0 : (inc_mode == 2) ? 4'hf : 4'($urandom);
  end

  task automatic step();
    @(posedge clk);
    #1;
  endtask

  task automatic bus_rd(input int a);
    rd = 1'b1; addr = 10'(a); step(); rd = 1'b0;
  endtask

  task automatic bus_wr(input int a, input int d);
    wr = 1'b1; addr = 10'(a); wdata = 16'(d); step(); wr = 1'b0;
  endtask

  task automatic check(input bit ok, input string req, input logic [15:0] got, input logic [15:0] expv);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s got %h expected %h", req, got, expv);
    end
  endtask

  initial begin
    repeat (2000000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks + ref_a.checks + ref_b.checks,
               errors + ref_a.errors + ref_b.errors);
      $finish;
    end
  end

  initial begin
    repeat (4) step();
    rst_n = 1'b1;
    step();
    @(negedge clk);
    check(rdata_a == 16'h0 && !irq_a, "R1", rdata_a, 16'h0);
    check(rdata_b == 16'h0 && !irq_b, "R1", rdata_b, 16'h0);
    step();
    phase = 1;                              // R1 reset reads
    bus_rd(256); bus_rd(4); bus_rd(8);
    phase = 2; inc_mode = 1;                // R2 live counting, shadow unchanged
    repeat (40) step();
    bus_rd(256); bus_rd(257);
    phase = 3;                              // R3 snapshot during increments
    bus_wr(0, 1);
    inc_mode = 0;
    step(); step();
    phase = 4;                              // R4 slicing and latency
    for (int i = 0; i < NB; i++)
      for (int s = 0; s < 4; s++) bus_rd(256 + 4*i + s);
    step();
    phase = 6; inc_mode = 2;                // R6 wraps of the narrow bank
    repeat (90) step();
    bus_wr(0, 1);
    bus_rd(256); bus_rd(258);
    phase = 7;                              // R7 clear-on-read with coinciding wraps
    for (int k = 0; k < 4; k++) bus_rd(4 + k);
    for (int k = 0; k < 4; k++) bus_rd(4 + k);
    repeat (70) step();
    inc_mode = 0;
    step(); step();
    phase = 8;                              // R8 masks and interrupt
    bus_wr(8, 16'hffff); bus_wr(9, 16'h000f);
    rd = 1'b1; wr = 1'b1; addr = 10'd10; wdata = 16'h1234; step(); rd = 1'b0; wr = 1'b0;
    bus_rd(8); bus_rd(9); bus_rd(10); bus_rd(11);
    step();
    @(negedge clk);
    check(irq_b == 1'b1, "R8", 16'(irq_b), 16'h1);
    step();
    bus_rd(4); bus_rd(5);
    step();
    @(negedge clk);
    check(irq_b == 1'b0, "R8", 16'(irq_b), 16'h0);
    step();
    bus_wr(8, 0); bus_wr(9, 0); bus_wr(10, 0);
    phase = 5; inc_mode = 1;                // R5 clear behaviour
    repeat (20) step();
    bus_wr(0, 2);
    repeat (5) step();
    bus_wr(0, 3);
    inc_mode = 0;
    for (int i = 0; i < 4; i++) bus_rd(256 + 4*i);
    bus_wr(0, 1);
    for (int i = 0; i < NA; i++) begin bus_rd(256 + 4*i); bus_rd(257 + 4*i); end
    phase = 9;                              // R9 unused space
    bus_wr(1, 16'hffff); bus_wr(12, 16'hffff); bus_wr(300, 16'hffff);
    bus_rd(0); bus_rd(1); bus_rd(3); bus_rd(12); bus_rd(200);
    bus_rd(256 + 4*NA); bus_rd(256 + 4*63 + 1); bus_rd(5); bus_rd(7); bus_rd(256 + 3);
    step();
    @(negedge clk);
    check(rdata_a == 16'h0 && rdata_b == 16'h0, "R9", rdata_a | rdata_b, 16'h0);
    repeat (3) step();
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks + ref_a.checks + ref_b.checks,
             errors + ref_a.errors + ref_b.errors);
    $finish;
  end
endmodule